// File: doc/BRIEF.md
# Sticky Fault Register with Write-One-To-Clear and Alert

This block keeps a set of fault flags that stay set once a fault occurs. Each flag is set by a one-cycle event strobe from a detector elsewhere in the chip. It stays set until the host clears it by writing a one to its bit position. A summary flag records that at least one fault has occurred. An active-low alert pin tells the host to service the register, but only when the masks allow it.

The host clears faults in two steps. First it clears the individual flags; several can be cleared in one write. Then it writes one to the summary flag. The summary flag only accepts that clear once every fault flag reads zero.

The top bit marks that all registers have returned to their defaults, so reset sets it. The lowest bit records a host interface error. Three separate error sources are folded into it:
- a transmit request while the transmit buffer is empty,
- a watchdog expiry,
- an invalid command.

Top module: `fault_latch`

## Requirements
- R1: An event strobe on input bit i sets faultReg[i] at the next rising clock edge. The bit then stays set until a host write with wrEn=1 carries a one in position i.
- R2: A host write with wrEn=1 clears, at the next edge, every faultReg bit whose wrData bit is one. Bits whose wrData bit is zero keep their value, so several bits can be cleared in a single write.
- R3: faultSum is one whenever any bit of faultReg is one. Any cycle in which a fault bit is set also sets faultSum at the same edge.
- R4: alertN is low exactly when all of the following hold: faultSum is one, alertMaskGlobal is one, and some bit of faultReg is one with its faultMask bit also one. It follows its inputs and the current register state without an added cycle.
- R5: sumClrWr=1 clears faultSum at the next edge only if faultReg is all zero in that cycle. Otherwise the write is ignored and faultSum stays one.
- R6: If an event and a host write with a one target the same bit in the same cycle, the bit is set after the edge; the event wins.
- R7: During and right after reset, faultReg reads 0x80 (bit 7 set, reporting that all registers returned to their defaults) and faultSum reads one.
- R8: Bit 0 (interface error) is set at the next edge when any of errTxEmpty, errWdog or errBadCmd is one, just as a direct event on bit 0 would set it.
- R9: If sumClrWr=1 arrives while faultReg is zero but an event sets a fault bit in the same cycle, faultSum stays one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| faultEvt | input | 8 | One-cycle fault event strobes, one per bit |
| errTxEmpty | input | 1 | Transmit request with empty buffer; sets bit 0 |
| errWdog | input | 1 | Watchdog expiry; sets bit 0 |
| errBadCmd | input | 1 | Invalid command written; sets bit 0 |
| wrEn | input | 1 | Host write strobe for the fault register |
| wrData | input | 8 | Host write data; ones clear the matching bits |
| faultMask | input | 8 | Per-bit alert enable |
| alertMaskGlobal | input | 1 | Global fault alert enable |
| sumClrWr | input | 1 | Host writes one to the summary flag |
| faultReg | output | 8 | Latched fault flags |
| faultSum | output | 1 | Summary fault flag |
| alertN | output | 1 | Active-low alert pin |

## Verification
The hardest cases to reach from the ports are the collisions on a single edge. One is an event and a clearing write on the same bit. The other is a summary-clear write that lands on an all-zero register in the same cycle as a fresh event. Both need the register to be brought to a precise state first. Directed sequences therefore drain the register with multi-bit writes, clear the summary flag, and then fire the event and the write together. A long random phase follows, with writes biased toward all-ones so that the summary flag really does fall and rise many times. A behavioural model compares every output on every clock.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
  parameter int unsigned FLT_W = 8;
  localparam int unsigned ERR_BIT = 0;
  localparam int unsigned PWR_BIT = FLT_W - 1;
  localparam logic [FLT_W-1:0] RST_VAL = FLT_W'(1) << PWR_BIT;

  // strobes from control to datapath
  typedef struct packed {
    logic [FLT_W-1:0] setBits;
    logic [FLT_W-1:0] clrBits;
    logic             sumSet;
    logic             sumClr;
  } fltStrobe_t;
endpackage

// File: rtl/fault_latch_ctrl.sv
module fault_latch_ctrl
  import fault_latch_pkg::*;
(
  input  logic [FLT_W-1:0] faultEvt,
  input  logic             errTxEmpty,
  input  logic             errWdog,
  input  logic             errBadCmd,
  input  logic             wrEn,
  input  logic [FLT_W-1:0] wrData,
  input  logic             sumClrWr,
  input  logic [FLT_W-1:0] faultRegQ,
  output fltStrobe_t       strb
);
  logic             errAny;
  logic [FLT_W-1:0] setVec;
  logic [FLT_W-1:0] clrVec;
  logic             regEmpty;

  assign errAny = errTxEmpty | errWdog | errBadCmd;

  // per-bit set/clear decode; events take priority over clears
  for (genvar i = 0; i < FLT_W; i++) begin : g_bit
    if (i == ERR_BIT) begin : g_err
      assign setVec[i] = faultEvt[i] | errAny;
    end else begin : g_plain
      assign setVec[i] = faultEvt[i];
    end
    assign clrVec[i] = wrEn & wrData[i] & ~setVec[i];
  end

  assign regEmpty = (faultRegQ == '0);

  always_comb begin
    strb         = '0;
    strb.setBits = setVec;
    strb.clrBits = clrVec;
    strb.sumSet  = |setVec;
    strb.sumClr  = sumClrWr & regEmpty & ~(|setVec);
  end
endmodule

// File: rtl/fault_latch_dp.sv
module fault_latch_dp
  import fault_latch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  fltStrobe_t       strb,
  input  logic [FLT_W-1:0] faultMask,
  input  logic             alertMaskGlobal,
  output logic [FLT_W-1:0] faultReg,
  output logic             faultSum,
  output logic             alertN
);
  logic maskedHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultReg <= RST_VAL;
      faultSum <= 1'b1;
    end else begin
      faultReg <= (faultReg & ~strb.clrBits) | strb.setBits;
      if (strb.sumSet)      faultSum <= 1'b1;
      else if (strb.sumClr) faultSum <= 1'b0;
    end
  end

  assign maskedHit = |(faultReg & faultMask);
  assign alertN    = ~(faultSum & alertMaskGlobal & maskedHit);

  for (genvar i = 0; i < FLT_W; i++) begin : g_chk
    p_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
      faultReg[i] && !strb.clrBits[i] |=> faultReg[i]);
    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb.setBits[i] |=> faultReg[i]);
  end

  p_sum_covers_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|faultReg) |-> faultSum);
  p_alert_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    !alertN |-> (faultSum && alertMaskGlobal && (faultReg != '0)));
  p_sum_clr_guard_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultSum) |-> ($past(faultReg) == '0));
endmodule

// File: rtl/fault_latch.sv
module fault_latch
  import fault_latch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [FLT_W-1:0] faultEvt,
  input  logic             errTxEmpty,
  input  logic             errWdog,
  input  logic             errBadCmd,
  input  logic             wrEn,
  input  logic [FLT_W-1:0] wrData,
  input  logic [FLT_W-1:0] faultMask,
  input  logic             alertMaskGlobal,
  input  logic             sumClrWr,
  output logic [FLT_W-1:0] faultReg,
  output logic             faultSum,
  output logic             alertN
);
  fltStrobe_t strb;

  fault_latch_ctrl u_ctrl (
    .faultEvt  (faultEvt),
    .errTxEmpty(errTxEmpty),
    .errWdog   (errWdog),
    .errBadCmd (errBadCmd),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .sumClrWr  (sumClrWr),
    .faultRegQ (faultReg),
    .strb      (strb)
  );

  fault_latch_dp u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .faultMask      (faultMask),
    .alertMaskGlobal(alertMaskGlobal),
    .faultReg       (faultReg),
    .faultSum       (faultSum),
    .alertN         (alertN)
  );

  p_err_fold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errTxEmpty || errWdog || errBadCmd) |=> faultReg[ERR_BIT]);
  p_sum_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultEvt != '0) |=> faultSum);
endmodule

// File: tb/fault_latch_tb.sv
module fault_latch_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] faultEvt = '0;
  logic       errTxEmpty = 1'b0, errWdog = 1'b0, errBadCmd = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] faultMask = '0;
  logic       alertMaskGlobal = 1'b0;
  logic       sumClrWr = 1'b0;
  logic [7:0] faultReg;
  logic       faultSum, alertN;

  int nVec = 0;
  int nFail = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0] refReg;
  bit         refSum;

  always #10 clk = ~clk;  // 50 MHz

  fault_latch u_dut (
    .clk(clk), .rstN(rstN), .faultEvt(faultEvt),
    .errTxEmpty(errTxEmpty), .errWdog(errWdog), .errBadCmd(errBadCmd),
    .wrEn(wrEn), .wrData(wrData), .faultMask(faultMask),
    .alertMaskGlobal(alertMaskGlobal), .sumClrWr(sumClrWr),
    .faultReg(faultReg), .faultSum(faultSum), .alertN(alertN)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit expAlertN();
    return !(refSum && alertMaskGlobal && ((refReg & faultMask) != 0));
  endfunction

  // one clock of stimulus; entered and left just after a falling edge
  task automatic step(string tag, logic [7:0] evt, logic [2:0] err,
                      logic wr, logic [7:0] data, logic sc,
                      logic [7:0] msk, logic gm);
    logic [7:0] setv, clrv, nReg;
    bit nSum;
    faultEvt = evt; {errTxEmpty, errWdog, errBadCmd} = err;
    wrEn = wr; wrData = data; sumClrWr = sc;
    faultMask = msk; alertMaskGlobal = gm;
    #2;
    chk(tag, "alertN", {7'b0, alertN}, {7'b0, expAlertN()});
    setv = evt | ((err != 0) ? 8'h01 : 8'h00);
    clrv = wr ? (data & ~setv) : 8'h00;
    nReg = (refReg & ~clrv) | setv;
    if (setv != 0) nSum = 1;
    else if (sc && refReg == 0) nSum = 0;
    else nSum = refSum;
    @(posedge clk);
    refReg = nReg; refSum = nSum;
    @(negedge clk);
    #2;
    chk(tag, "faultReg", faultReg, refReg);
    chk(tag, "faultSum", {7'b0, faultSum}, {7'b0, refSum});
    chk(tag, "alertN", {7'b0, alertN}, {7'b0, expAlertN()});
  endtask

  task automatic idle(string tag, int n, logic [7:0] msk, logic gm);
    for (int k = 0; k < n; k++) step(tag, 8'h00, 3'b000, 0, 8'h00, 0, msk, gm);
  endtask

  initial begin
    refReg = 8'h80; refSum = 1;
    repeat (3) @(negedge clk);
    // R7: reset value while held and after release
    chk("R7", "faultReg", faultReg, 8'h80);
    chk("R7", "faultSum", {7'b0, faultSum}, 8'h01);
    rstN = 1'b1;
    #2;
    chk("R7", "faultReg", faultReg, 8'h80);
    idle("R7", 2, 8'h00, 0);

    // R4: mask gating of the alert pin
    step("R4", 0, 0, 0, 0, 0, 8'h80, 1);
    step("R4", 0, 0, 0, 0, 0, 8'h80, 0);
    step("R4", 0, 0, 0, 0, 0, 8'h7F, 1);

    // R5: summary clear ignored while bit 7 set, then accepted
    step("R5", 0, 0, 0, 0, 1, 8'hFF, 1);
    step("R2", 0, 0, 1, 8'h80, 0, 8'hFF, 1);
    step("R5", 0, 0, 0, 0, 1, 8'hFF, 1);

    // R1: event sets and bit holds
    step("R1", 8'h08, 0, 0, 0, 0, 8'hFF, 1);
    idle("R1", 3, 8'hFF, 1);
    // R2: writing zeros leaves the bit; multi-bit clear
    step("R2", 0, 0, 1, 8'hF7, 0, 8'hFF, 1);
    step("R1", 8'h22, 0, 0, 0, 0, 8'hFF, 1);
    step("R2", 0, 0, 1, 8'h2A, 0, 8'hFF, 1);
    // R6: event beats clear on the same bit
    step("R6", 8'h04, 0, 1, 8'h04, 0, 8'h04, 1);
    step("R2", 0, 0, 1, 8'h04, 0, 8'h04, 1);
    step("R5", 0, 0, 0, 0, 1, 8'hFF, 1);

    // R8: each error source sets bit 0
    for (int s = 0; s < 3; s++) begin
      step("R8", 0, 3'b001 << s, 0, 0, 0, 8'h01, 1);
      step("R2", 0, 0, 1, 8'h01, 0, 8'h01, 1);
      step("R5", 0, 0, 0, 0, 1, 8'h01, 1);
    end

    // R9: summary clear collides with a fresh event
    step("R9", 8'h10, 0, 0, 0, 1, 8'hFF, 1);
    step("R2", 0, 0, 1, 8'hFF, 0, 8'hFF, 1);
    step("R5", 0, 0, 0, 0, 1, 8'hFF, 1);
    // R3: event on a bit sets summary again
    step("R3", 8'h40, 0, 0, 0, 0, 8'h00, 1);

    // random mix: R1 R2 R3 R4 R5 R6 R8 R9
    for (int n = 0; n < 600; n++) begin
      logic [7:0] e, d;
      logic [2:0] er;
      e  = ($urandom % 4 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
      er = ($urandom % 12 == 0) ? 3'(1 << ($urandom % 3)) : 3'b000;
      d  = ($urandom % 2 == 0) ? 8'hFF : 8'($urandom);
      step("R1 R2 R3 R4 R5 R6 R8 R9", e, er, ($urandom % 3 == 0), d,
           ($urandom % 3 == 0), 8'($urandom), ($urandom % 4 != 0));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end
endmodule